// File: doc/BRIEF.md
# Receive FIFO with Fill Trigger and Character Timeout

This block buffers bytes arriving from a serial receiver in a small circular queue and tells the bus side when enough data is waiting. A byte is taken in on any cycle where the receiver strobes it and reception is enabled. Bus reads pop the oldest byte. The current fill count is presented as its own output.

A level flag (`level_flag`) goes high in one of two cases. The first is when a store brings the fill up to a programmable trigger level of 1, 4, 8 or 14 bytes. The second is when fifteen character times pass after a store that left the fill below the trigger, so a short message still gets noticed. The flag falls when a pop takes the fill below the trigger. A receive interrupt follows the events that raise the flag, gated by an interrupt enable. A flush strobe empties the queue.

Two state machines carry the control. The timeout machine has two states. `TMO_IDLE` moves to `TMO_RUN` on a store that leaves the fill below the trigger. `TMO_RUN` restarts on each such store. It goes back to `TMO_IDLE` on expiry (the fifteenth character tick), on a store that reaches the trigger, or on a flush. The flag machine also has two states. `FLAG_LOW` moves to `FLAG_HIGH` on a trigger hit or a timeout expiry. `FLAG_HIGH` moves back to `FLAG_LOW` on a pop that leaves the fill below the trigger, or on a flush.

Top module: `rxq_core`

## Requirements
- R1: After reset the fill count is 0, `level_flag` and `rx_irq` are low, the trigger level is 1 and the timeout machine is idle.
- R2: A byte on `rx_byte` is stored at the clock edge where `rx_valid` and `rx_en` are high and the fill is below 16. The fill count rises by one at that edge. `head_byte` always shows the oldest stored byte, so bytes leave in arrival order.
- R3: A byte offered while `rx_en` is low, or while the fill is 16 with no pop in the same cycle, is dropped and leaves the count and contents unchanged.
- R4: A pulse on `rx_pop` with a non-empty queue removes the oldest byte and lowers the count by one at that edge. A pop on an empty queue changes nothing.
- R5: A store and a pop in the same cycle leave the count unchanged while the queue advances.
- R6: A pulse on `trig_load` latches `trig_sel` as the trigger level: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8, 2'b11 gives 14. The new level applies from the following cycle.
- R7: A store that makes the fill equal to or above the trigger sets `level_flag` at that edge and cancels any running timeout.
- R8: A pop that leaves the fill below the trigger clears `level_flag` at that edge, unless the same edge sets it.
- R9: A store that leaves the fill below the trigger restarts the timeout. While the timeout runs, `char_tick` pulses are counted, and the fifteenth one sets `level_flag` and returns the timeout to idle. A tick in the cycle of a store is not counted.
- R10: `rx_irq` rises together with any event that sets the flag, when `rx_irq_en` is high. It falls at the edge after `rx_irq_en` is low, or when the flag is cleared. It is never high while `level_flag` is low.
- R11: `fifo_flush` empties the queue and clears the flag, the interrupt and the timeout at that edge. It takes priority over a store or pop in the same cycle, and does not change the trigger level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | DW (8) | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_en | input | 1 | Reception enable |
| rx_pop | input | 1 | Pop the oldest byte |
| trig_load | input | 1 | Latch a new trigger select |
| trig_sel | input | 2 | Trigger level select |
| fifo_flush | input | 1 | Empty the queue |
| rx_irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One-cycle pulse per character time |
| head_byte | output | DW (8) | Oldest stored byte |
| fill_count | output | 5 | Number of stored bytes (0 to 16) |
| level_flag | output | 1 | Data-ready flag (trigger or timeout) |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions check several rules on every cycle:
- the fill never passes 16;
- a flush leaves an empty queue with flag and interrupt low;
- disabled or overflowing stores do not change the count, and neither does a pop on an empty queue;
- a paired store and pop keep the count;
- the interrupt is never high without the flag or after the enable was low.

The bench scenarios are needed for the rest:
- the order of bytes at `head_byte`;
- the decoding of each trigger select;
- the exact cycle on which the fifteenth tick raises the flag;
- the interaction of pops with the trigger threshold.

These are compared against a cycle model built from the requirements.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [0:0] {
        TMO_IDLE = 1'b0,
        TMO_RUN  = 1'b1
    } tmo_state_e;

    typedef enum logic [0:0] {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

    // Trigger select to fill level.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        unique case (sel)
            2'b00: lvl = 5'd1;
            2'b01: lvl = 5'd4;
            2'b10: lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
    parameter int DW = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pull,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q;
    logic [AW-1:0] rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= bump(wr_q);
            end
            if (pull) begin
                rd_q <= bump(rd_q);
            end
            unique case ({push, pull})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rd_q];
    assign count = cnt_q;

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import rxq_pkg::*;
#(
    parameter int TMO_CHARS = 15,
    localparam int TW = (TMO_CHARS > 1) ? $clog2(TMO_CHARS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic restart,
    input  logic cancel,
    input  logic tick,
    output logic expire
);

    tmo_state_e    st_q, st_d;
    logic [TW-1:0] n_q, n_d;
    logic          last_tick;

    assign last_tick = (n_q == TW'(TMO_CHARS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TMO_IDLE;
            n_q  <= '0;
        end else begin
            st_q <= st_d;
            n_q  <= n_d;
        end
    end

    always_comb begin
        st_d = st_q;
        n_d  = n_q;
        if (flush || cancel) begin
            st_d = TMO_IDLE;
            n_d  = '0;
        end else if (restart) begin
            st_d = TMO_RUN;
            n_d  = '0;
        end else begin
            unique case (st_q)
                TMO_IDLE: begin
                    n_d = '0;
                end
                TMO_RUN: begin
                    if (tick) begin
                        if (last_tick) begin
                            st_d = TMO_IDLE;
                            n_d  = '0;
                        end else begin
                            n_d = n_q + TW'(1);
                        end
                    end
                end
                default: begin
                    st_d = TMO_IDLE;
                    n_d  = '0;
                end
            endcase
        end
    end

    always_comb begin
        expire = (st_q == TMO_RUN) && tick && last_tick
                 && !restart && !cancel && !flush;
    end

endmodule

// File: rtl/rxq_flag_ctl.sv
module rxq_flag_ctl
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    flag_state_e st_q, st_d;
    logic        irq_q, irq_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLAG_LOW;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        irq_d = irq_q;
        if (flush) begin
            st_d  = FLAG_LOW;
            irq_d = 1'b0;
        end else begin
            unique case (st_q)
                FLAG_LOW: begin
                    if (set_ev) begin
                        st_d = FLAG_HIGH;
                    end
                end
                FLAG_HIGH: begin
                    if (!set_ev && clr_ev) begin
                        st_d = FLAG_LOW;
                    end
                end
                default: st_d = FLAG_LOW;
            endcase
            if (set_ev && irq_en) begin
                irq_d = 1'b1;
            end else if (!irq_en || clr_ev) begin
                irq_d = 1'b0;
            end
        end
    end

    always_comb begin
        flag = (st_q == FLAG_HIGH);
        irq  = irq_q;
    end

endmodule

// File: rtl/rxq_core.sv
module rxq_core
    import rxq_pkg::*;
#(
    parameter int DW = 8,
    parameter int DEPTH = 16,
    parameter int TMO_CHARS = 15,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_valid,
    input  logic          rx_en,
    input  logic          rx_pop,
    input  logic          trig_load,
    input  logic [1:0]    trig_sel,
    input  logic          fifo_flush,
    input  logic          rx_irq_en,
    input  logic          char_tick,
    output logic [DW-1:0] head_byte,
    output logic [CW-1:0] fill_count,
    output logic          level_flag,
    output logic          rx_irq
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] trig_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic          store;
    logic          pull;
    logic          reach;
    logic          below;
    logic          expire;
    logic          set_ev;
    logic          clr_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= CW'(1);
        end else if (trig_load) begin
            trig_q <= CW'(trig_level(trig_sel));
        end
    end

    always_comb begin
        store    = rx_valid && rx_en && (cnt != FULL_CNT) && !fifo_flush;
        pull     = rx_pop && (cnt != '0) && !fifo_flush;
        cnt_next = cnt + CW'(store) - CW'(pull);
        reach    = store && (cnt_next >= trig_q);
        below    = store && (cnt_next < trig_q);
        set_ev   = reach || expire;
        clr_ev   = pull && (cnt_next < trig_q);
    end

    rxq_buffer #(
        .DW(DW),
        .DEPTH(DEPTH)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_flush),
        .push  (store),
        .pull  (pull),
        .wdata (rx_byte),
        .rdata (head_byte),
        .count (cnt)
    );

    rxq_timeout #(
        .TMO_CHARS(TMO_CHARS)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (fifo_flush),
        .restart (below),
        .cancel  (reach),
        .tick    (char_tick),
        .expire  (expire)
    );

    rxq_flag_ctl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (fifo_flush),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .irq_en (rx_irq_en),
        .flag   (level_flag),
        .irq    (rx_irq)
    );

    assign fill_count = cnt;

endmodule

// File: rtl/rxq_core_chk.sv
module rxq_core_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_en,
    input logic          rx_pop,
    input logic          fifo_flush,
    input logic          rx_irq_en,
    input logic [CW-1:0] fill_count,
    input logic          level_flag,
    input logic          rx_irq
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R2: fill never exceeds the depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_CNT);

    // R11: flush empties and clears
    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fill_count == '0) && !level_flag && !rx_irq);

    // R3: disabled reception with no pop keeps the count
    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_flush && !rx_en && !rx_pop) |=> $stable(fill_count));

    // R3: full queue with no pop drops the byte
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_flush && fill_count == FULL_CNT && !rx_pop) |=> fill_count == FULL_CNT);

    // R4: pop on empty without a store changes nothing
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_flush && fill_count == '0 && rx_pop && !(rx_valid && rx_en))
        |=> fill_count == '0);

    // R5: paired store and pop keep the count
    p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_flush && rx_valid && rx_en && rx_pop
         && fill_count != '0 && fill_count != FULL_CNT) |=> $stable(fill_count));

    // R10: interrupt implies flag
    p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> level_flag);

    // R10: interrupt low after the enable was low
    p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |=> !rx_irq);

endmodule

bind rxq_core rxq_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_en      (rx_en),
    .rx_pop     (rx_pop),
    .fifo_flush (fifo_flush),
    .rx_irq_en  (rx_irq_en),
    .fill_count (fill_count),
    .level_flag (level_flag),
    .rx_irq     (rx_irq)
);

// File: tb/sim_rxq_core.sv
`timescale 1ns/1ps
module sim_rxq_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_pop = 1'b0;
    logic       trig_load = 1'b0;
    logic [1:0] trig_sel = '0;
    logic       fifo_flush = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] head_byte;
    logic [4:0] fill_count;
    logic       level_flag;
    logic       rx_irq;

    always #2 clk = ~clk;

    rxq_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_en      (rx_en),
        .rx_pop     (rx_pop),
        .trig_load  (trig_load),
        .trig_sel   (trig_sel),
        .fifo_flush (fifo_flush),
        .rx_irq_en  (rx_irq_en),
        .char_tick  (char_tick),
        .head_byte  (head_byte),
        .fill_count (fill_count),
        .level_flag (level_flag),
        .rx_irq     (rx_irq)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state
    logic [7:0] m_mem [16];
    int m_wr, m_rd, m_cnt, m_trig, m_tcnt;
    bit m_flag, m_irq, m_trun;

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_trig = 1; m_tcnt = 0;
            m_flag = 0; m_irq = 0; m_trun = 0;
        end else begin
            bit st, pp, setev, clr;
            int nc;
            if (fifo_flush) begin
                m_wr = 0; m_rd = 0; m_cnt = 0; m_flag = 0; m_irq = 0;
                m_trun = 0; m_tcnt = 0;
            end else begin
                st = rx_valid && rx_en && (m_cnt < 16);
                pp = rx_pop && (m_cnt > 0);
                if (st) begin m_mem[m_wr] = rx_byte; m_wr = (m_wr + 1) % 16; end
                if (pp) m_rd = (m_rd + 1) % 16;
                nc = m_cnt + (st ? 1 : 0) - (pp ? 1 : 0);
                setev = 0;
                if (st) begin
                    if (nc >= m_trig) begin setev = 1; m_trun = 0; m_tcnt = 0; end
                    else begin m_trun = 1; m_tcnt = 0; end
                end else if (m_trun && char_tick) begin
                    if (m_tcnt == 14) begin setev = 1; m_trun = 0; m_tcnt = 0; end
                    else m_tcnt++;
                end
                clr = pp && (nc < m_trig);
                if (setev) m_flag = 1; else if (clr) m_flag = 0;
                if (setev && rx_irq_en) m_irq = 1;
                else if (!rx_irq_en || clr) m_irq = 0;
                m_cnt = nc;
            end
            if (trig_load) m_trig = lvl_of(trig_sel);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("fill_count", fill_count, m_cnt);
        chk("level_flag", level_flag, m_flag);
        chk("rx_irq", rx_irq, m_irq);
        if (m_cnt > 0) chk("head_byte", head_byte, m_mem[m_rd]);
    endtask

    // advance to the next negedge, compare, then drive new inputs
    task automatic drive(input bit v, input logic [7:0] b, input bit p,
                         input bit t, input bit ld, input logic [1:0] sel,
                         input bit fl);
        @(negedge clk);
        compare();
        rx_valid = v; rx_byte = b; rx_pop = p; char_tick = t;
        trig_load = ld; trig_sel = sel; fifo_flush = fl;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0, 0, 2'b00, 0);
    endtask

    task automatic rand_run(input int n, input int pv, input int pp,
                            input int pt, input bit tog_ie);
        for (int i = 0; i < n; i++) begin
            drive(($urandom % 100) < pv, 8'($urandom), ($urandom % 100) < pp,
                  ($urandom % 100) < pt, ($urandom % 60) == 0,
                  2'($urandom), ($urandom % 150) == 0);
            if (tog_ie && ($urandom % 20) == 0) rx_irq_en = ~rx_irq_en;
            rx_en = ($urandom % 10) != 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", tag);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c1d));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then level 1 hit by a single byte
        tag = "R1";
        idle(2);
        chk("reset count", fill_count, 0);
        chk("reset flag", level_flag, 0);
        chk("reset irq", rx_irq, 0);
        rx_en = 1; rx_irq_en = 1;
        drive(1, 8'hA5, 0, 0, 0, 2'b00, 0);
        idle(1);
        chk("flag at default level", level_flag, 1);
        chk("irq at default level", rx_irq, 1);

        // R6: trigger 4, R7 set on fourth byte
        tag = "R6";
        drive(0, 8'h00, 0, 0, 1, 2'b01, 1);
        for (int i = 0; i < 3; i++) drive(1, 8'(8'h10 + i), 0, 0, 0, 2'b00, 0);
        idle(1);
        chk("flag below level 4", level_flag, 0);
        tag = "R7";
        drive(1, 8'h13, 0, 0, 0, 2'b00, 0);
        idle(1);
        chk("flag at level 4", level_flag, 1);
        // R2: order
        tag = "R2";
        chk("head first", head_byte, 8'h10);
        // R8: pop below trigger clears
        tag = "R8";
        drive(0, 8'h00, 1, 0, 0, 2'b00, 0);
        idle(1);
        chk("flag after pop below 4", level_flag, 0);
        chk("head after pop", head_byte, 8'h11);

        // R3: fill beyond 16 and disabled bytes
        tag = "R3";
        drive(0, 8'h00, 0, 0, 1, 2'b11, 1);
        for (int i = 0; i < 20; i++) drive(1, 8'(i), 0, 0, 0, 2'b00, 0);
        idle(1);
        chk("count saturates", fill_count, 16);
        chk("head oldest kept", head_byte, 8'h00);
        drive(0, 8'h00, 1, 0, 0, 2'b00, 0);
        rx_en = 0;
        drive(1, 8'hEE, 0, 0, 0, 2'b00, 0);
        idle(1);
        chk("disabled byte ignored", fill_count, 15);
        rx_en = 1;

        // R5: store and pop together
        tag = "R5";
        drive(1, 8'h77, 1, 0, 0, 2'b00, 0);
        idle(1);
        chk("paired count", fill_count, 15);

        // R11: flush with a same-cycle store
        tag = "R11";
        drive(1, 8'h55, 1, 0, 0, 2'b00, 1);
        idle(1);
        chk("flush count", fill_count, 0);
        chk("flush flag", level_flag, 0);

        // R4: pop on empty
        tag = "R4";
        drive(0, 8'h00, 1, 0, 0, 2'b00, 0);
        idle(1);
        chk("empty pop count", fill_count, 0);

        // R9: timeout at trigger 14 (kept across flush)
        tag = "R9";
        drive(1, 8'hC1, 0, 1, 0, 2'b00, 0);
        drive(1, 8'hC2, 0, 0, 0, 2'b00, 0);
        for (int i = 0; i < 14; i++) drive(0, 8'h00, 0, 1, 0, 2'b00, 0);
        idle(1);
        chk("flag before 15th tick", level_flag, 0);
        drive(0, 8'h00, 0, 1, 0, 2'b00, 0);
        idle(1);
        chk("flag after 15th tick", level_flag, 1);
        chk("irq after timeout", rx_irq, 1);
        // R10: enable low drops the interrupt
        tag = "R10";
        rx_irq_en = 0;
        idle(2);
        chk("irq after enable low", rx_irq, 0);
        chk("flag kept", level_flag, 1);

        // randomized phases checked against the model
        tag = "R2";  rand_run(1500, 60, 20, 10, 0);
        tag = "R8";  rand_run(1500, 35, 45, 10, 0);
        tag = "R9";  rand_run(2000, 8, 5, 60, 1);
        tag = "R10"; rand_run(1500, 40, 35, 30, 1);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule